// File: doc/BRIEF.md
# Vector-Length Control Register Access Arbiter

This block decides, in a single combinational step, what happens when software tries to read or write a vector-length control register. The register can be reached under two names. Its own name belongs to the hypervisor level. The second name is a lower-level alias that the hypervisor level can also use. The block looks at the requesting privilege level, at which name was used, and at the trap and enable controls of every level above the requester. From these it produces exactly one verdict: the instruction is undefined, it traps to a given level with a given syndrome class, it goes through to one of the two physical registers, or it is redirected to a fixed slot in the nested-virtualization save area.

The core's system-register pipeline instantiates the block beside its decode stage. The verdict flags steer the exception unit or the register file. Reads and writes share the same permission logic; the direction bit only sets which data-enable is raised. The register storage and the exception handling live elsewhere.

Top module: `sracc_perm_check`

## Requirements
- R1: When the feature-present input is 0, or the requesting level is 0, the verdict is undefined.
- R2: A level-1 access using the own name traps to level 2 with syndrome class 0x18 when nested-virtualization bit 0 is 1, and is undefined otherwise.
- R3: At level 2, and for a level-1 access through the alias, the first check is a secure-debug priority undefined: top level present, priority condition set and top-level enable 0.
- R4: After that check, a level-2 access traps to level 2 with class 0x19 when not in host mode and the level-2 trap bit is 1. It also traps to level 2 with class 0x19 when in host mode and bit 0 of the level-2 enable field is 0.
- R5: After the level-2 checks, a present top level with its enable at 0 gives undefined when the secure-debug undefined condition holds, and a trap to level 3 with class 0x19 otherwise.
- R6: At level 3, a top-level enable of 0 traps to level 3 with class 0x19. Otherwise the access goes through: the own name selects the level-2 register and the alias selects the level-1 register.
- R7: A level-1 alias access whose level-1 enable bit 0 is 0 traps to level 1 with class 0x19. This check follows the priority check of R3 and comes before every level-2 check.
- R8: For a level-1 alias access, the level-2 trap-bit check applies only when level 2 is enabled. The host-mode enable check of R4 applies unchanged.
- R9: A level-1 alias access that passes every check goes to the memory slot at offset 0x1E0 when all three nested-virtualization bits are 1. Otherwise it goes to the level-1 register.
- R10: A level-2 access that passes every check selects the level-2 register through the own name. Through the alias it selects the level-2 register in host mode and the level-1 register otherwise.
- R11: The verdict does not depend on the direction bit. The read enable or the write enable (never both) is 1 only for register or memory verdicts, and follows the direction bit.
- R12: Exactly one of the undefined, trap, register and memory flags is 1. The trap level and class are 0 unless trap is set. The register select (1 = level-2 register) is 0 unless register is set. The memory offset is 0 unless memory is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_lvl | input | 2 | Privilege level of the requester, 0 to 3 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alias | input | 1 | 1 = lower-level alias name used, 0 = own name |
| feat_on | input | 1 | The vector feature is implemented |
| top_present | input | 1 | Level 3 is implemented |
| top_en | input | 1 | Level-3 enable for vector register access |
| l2_trap | input | 1 | Level-2 trap bit, used outside host mode |
| l2_en | input | 2 | Level-2 enable field, bit 0 used in host mode |
| host_mode | input | 1 | Level 2 runs as host |
| l2_live | input | 1 | Level 2 is enabled in the current security state |
| nv_bits | input | 3 | Nested-virtualization control bits |
| l1_en | input | 2 | Level-1 enable field, bit 0 used |
| sdd_prio | input | 1 | Secure-debug priority undefined condition |
| sdd_undef | input | 1 | Secure-debug undefined condition |
| res_undef | output | 1 | Verdict: undefined instruction |
| res_trap | output | 1 | Verdict: trap |
| res_reg | output | 1 | Verdict: register access |
| res_mem | output | 1 | Verdict: save-area redirect |
| trap_lvl | output | 2 | Target level of the trap |
| trap_cls | output | 6 | Syndrome class of the trap |
| reg_sel_l2 | output | 1 | 1 = level-2 register, 0 = level-1 register |
| mem_ofs | output | 12 | Save-area offset for the redirect |
| rd_en | output | 1 | Read data transfer |
| wr_en | output | 1 | Write data transfer |

## Verification
The assertions check every settled input pattern against the structural rules: one verdict flag, trap and select fields clean outside their verdicts, the direction enables, the undefined result with no feature or at level 0, redirects only on fully qualified level-1 alias accesses, and the level-3 outcome. The priority order between competing conditions at level 1 and level 2 can only be seen in the bench's scenarios. These include the secure-debug undefined beating the level-1 trap, the gating of the trap bit by level-2 enable, and the host-mode alias selection. The bench sweeps every input combination against its own model.

// File: rtl/sracc_pkg.sv
package sracc_pkg;

  localparam int LVL_W = 2;
  localparam int CLS_W = 6;
  localparam int NV_W  = 3;

  localparam logic [CLS_W-1:0] CLS_NV_TRAP  = 6'h18;
  localparam logic [CLS_W-1:0] CLS_VEC_TRAP = 6'h19;

  localparam logic [LVL_W-1:0] LVL_0 = 2'd0;
  localparam logic [LVL_W-1:0] LVL_1 = 2'd1;
  localparam logic [LVL_W-1:0] LVL_2 = 2'd2;
  localparam logic [LVL_W-1:0] LVL_3 = 2'd3;

  typedef enum logic [1:0] {
    K_UNDEF = 2'd0,
    K_TRAP  = 2'd1,
    K_REG   = 2'd2,
    K_MEM   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [LVL_W-1:0]  tgt;
    logic [CLS_W-1:0]  cls;
    logic              sel_hi;
  } verdict_t;

  function automatic verdict_t v_undef();
    verdict_t v;
    v = '0;
    v.kind = K_UNDEF;
    return v;
  endfunction

  function automatic verdict_t v_trap(input logic [LVL_W-1:0] tgt,
                                      input logic [CLS_W-1:0] cls);
    verdict_t v;
    v = '0;
    v.kind = K_TRAP;
    v.tgt  = tgt;
    v.cls  = cls;
    return v;
  endfunction

  function automatic verdict_t v_reg(input logic sel_hi);
    verdict_t v;
    v = '0;
    v.kind   = K_REG;
    v.sel_hi = sel_hi;
    return v;
  endfunction

  function automatic verdict_t v_mem();
    verdict_t v;
    v = '0;
    v.kind = K_MEM;
    return v;
  endfunction

endpackage

// File: rtl/sracc_lower_chain.sv
// Checks that come after the level-1 checks: level-2 trap bit, host-mode
// enable, then the level-3 enable. Shared by level-2 and level-1 alias paths.
module sracc_lower_chain
  import sracc_pkg::*;
(
  input  logic     tz_live,
  input  logic     host_mode,
  input  logic     l2_trap,
  input  logic     l2_en0,
  input  logic     top_present,
  input  logic     top_en,
  input  logic     sdd_undef,
  output verdict_t blk,
  output logic     clear
);

  always_comb begin
    clear = 1'b0;
    blk   = v_undef();
    if (tz_live && !host_mode && l2_trap) begin
      blk = v_trap(LVL_2, CLS_VEC_TRAP);
    end else if (host_mode && !l2_en0) begin
      blk = v_trap(LVL_2, CLS_VEC_TRAP);
    end else if (top_present && !top_en) begin
      blk = sdd_undef ? v_undef() : v_trap(LVL_3, CLS_VEC_TRAP);
    end else begin
      clear = 1'b1;
    end
  end

endmodule

// File: rtl/sracc_target_sel.sv
// Chooses the destination of an access that passed every permission check.
module sracc_target_sel
  import sracc_pkg::*;
#(
  parameter int NVB = NV_W
) (
  input  logic [LVL_W-1:0] req_lvl,
  input  logic             req_alias,
  input  logic             host_mode,
  input  logic [NVB-1:0]   nv_bits,
  output verdict_t         pass_v
);

  localparam logic [NVB-1:0] NV_FULL = {NVB{1'b1}};

  always_comb begin
    unique case (req_lvl)
      LVL_1:   pass_v = (nv_bits == NV_FULL) ? v_mem() : v_reg(1'b0);
      LVL_2:   pass_v = v_reg(!req_alias || host_mode);
      LVL_3:   pass_v = v_reg(!req_alias);
      default: pass_v = v_undef();
    endcase
  end

endmodule

// File: rtl/sracc_out_enc.sv
// Expands a verdict into flat one-hot flags and qualified fields.
module sracc_out_enc
  import sracc_pkg::*;
#(
  parameter int               OFS_W    = 12,
  parameter logic [OFS_W-1:0] MEM_SLOT = 12'h1E0
) (
  input  verdict_t          v,
  input  logic              req_write,
  output logic              res_undef,
  output logic              res_trap,
  output logic              res_reg,
  output logic              res_mem,
  output logic [LVL_W-1:0]  trap_lvl,
  output logic [CLS_W-1:0]  trap_cls,
  output logic              reg_sel_l2,
  output logic [OFS_W-1:0]  mem_ofs,
  output logic              rd_en,
  output logic              wr_en
);

  logic moves;

  always_comb begin
    res_undef  = (v.kind == K_UNDEF);
    res_trap   = (v.kind == K_TRAP);
    res_reg    = (v.kind == K_REG);
    res_mem    = (v.kind == K_MEM);
    trap_lvl   = res_trap ? v.tgt : '0;
    trap_cls   = res_trap ? v.cls : '0;
    reg_sel_l2 = res_reg & v.sel_hi;
    mem_ofs    = res_mem ? MEM_SLOT : '0;
    moves      = res_reg | res_mem;
    rd_en      = moves & ~req_write;
    wr_en      = moves & req_write;
  end

endmodule

// File: rtl/sracc_perm_check.sv
// Access arbiter for the vector-length control register and its alias.
module sracc_perm_check
  import sracc_pkg::*;
#(
  parameter int               OFS_W    = 12,
  parameter logic [OFS_W-1:0] MEM_SLOT = 12'h1E0
) (
  input  logic [1:0]        req_lvl,
  input  logic              req_write,
  input  logic              req_alias,
  input  logic              feat_on,
  input  logic              top_present,
  input  logic              top_en,
  input  logic              l2_trap,
  input  logic [1:0]        l2_en,
  input  logic              host_mode,
  input  logic              l2_live,
  input  logic [2:0]        nv_bits,
  input  logic [1:0]        l1_en,
  input  logic              sdd_prio,
  input  logic              sdd_undef,
  output logic              res_undef,
  output logic              res_trap,
  output logic              res_reg,
  output logic              res_mem,
  output logic [1:0]        trap_lvl,
  output logic [5:0]        trap_cls,
  output logic              reg_sel_l2,
  output logic [OFS_W-1:0]  mem_ofs,
  output logic              rd_en,
  output logic              wr_en
);

  verdict_t chain_blk;
  logic     chain_clear;
  logic     tz_live;
  verdict_t pass_v;
  verdict_t final_v;
  logic     prio_undef;

  // The trap bit counts at level 2 always, at level 1 only with level 2 live.
  assign tz_live    = (req_lvl == LVL_2) ? 1'b1 : l2_live;
  assign prio_undef = top_present & sdd_prio & ~top_en;

  sracc_lower_chain u_chain (
    .tz_live     (tz_live),
    .host_mode   (host_mode),
    .l2_trap     (l2_trap),
    .l2_en0      (l2_en[0]),
    .top_present (top_present),
    .top_en      (top_en),
    .sdd_undef   (sdd_undef),
    .blk         (chain_blk),
    .clear       (chain_clear)
  );

  sracc_target_sel #(.NVB(NV_W)) u_target (
    .req_lvl   (req_lvl),
    .req_alias (req_alias),
    .host_mode (host_mode),
    .nv_bits   (nv_bits),
    .pass_v    (pass_v)
  );

  always_comb begin
    final_v = v_undef();
    if (feat_on && (req_lvl != LVL_0)) begin
      unique case (req_lvl)
        LVL_1: begin
          if (!req_alias) begin
            final_v = nv_bits[0] ? v_trap(LVL_2, CLS_NV_TRAP) : v_undef();
          end else if (prio_undef) begin
            final_v = v_undef();
          end else if (!l1_en[0]) begin
            final_v = v_trap(LVL_1, CLS_VEC_TRAP);
          end else begin
            final_v = chain_clear ? pass_v : chain_blk;
          end
        end
        LVL_2: begin
          if (prio_undef) final_v = v_undef();
          else            final_v = chain_clear ? pass_v : chain_blk;
        end
        default: begin
          final_v = top_en ? pass_v : v_trap(LVL_3, CLS_VEC_TRAP);
        end
      endcase
    end
  end

  sracc_out_enc #(.OFS_W(OFS_W), .MEM_SLOT(MEM_SLOT)) u_enc (
    .v          (final_v),
    .req_write  (req_write),
    .res_undef  (res_undef),
    .res_trap   (res_trap),
    .res_reg    (res_reg),
    .res_mem    (res_mem),
    .trap_lvl   (trap_lvl),
    .trap_cls   (trap_cls),
    .reg_sel_l2 (reg_sel_l2),
    .mem_ofs    (mem_ofs),
    .rd_en      (rd_en),
    .wr_en      (wr_en)
  );

endmodule

// File: rtl/sracc_perm_check_chk.sv
module sracc_perm_check_chk #(
  parameter int OFS_W = 12
) (
  input logic [1:0]       req_lvl,
  input logic             req_write,
  input logic             req_alias,
  input logic             feat_on,
  input logic             top_present,
  input logic             top_en,
  input logic [2:0]       nv_bits,
  input logic             res_undef,
  input logic             res_trap,
  input logic             res_reg,
  input logic             res_mem,
  input logic [1:0]       trap_lvl,
  input logic [5:0]       trap_cls,
  input logic             reg_sel_l2,
  input logic [OFS_W-1:0] mem_ofs,
  input logic             rd_en,
  input logic             wr_en
);

  logic settled;
  assign settled = !$isunknown({req_lvl, req_write, req_alias, feat_on,
                                top_present, top_en, nv_bits});

  always_comb begin
    if (settled) begin
      AST_ONE_VERDICT: assert ($onehot({res_undef, res_trap, res_reg, res_mem})); // R12
      AST_TRAP_FIELDS_CLEAN: assert (res_trap || (trap_lvl == 2'd0 && trap_cls == 6'd0)); // R12
      AST_SEL_CLEAN: assert (res_reg || !reg_sel_l2); // R12
      AST_OFS_CLEAN: assert (res_mem || mem_ofs == '0); // R12
      AST_NO_FEATURE_UNDEF: assert ((feat_on && req_lvl != 2'd0) || res_undef); // R1
      AST_MEM_QUALIFIED: assert (!res_mem || (req_lvl == 2'd1 && req_alias && nv_bits == 3'b111)); // R9
      AST_TOP_LEVEL_OUTCOME: assert (!(feat_on && req_lvl == 2'd3) ||
                                     (top_en ? (res_reg && reg_sel_l2 == !req_alias)
                                             : (res_trap && trap_lvl == 2'd3))); // R6
      AST_DIRECTION_ENABLES: assert ((rd_en == ((res_reg || res_mem) && !req_write)) &&
                                     (wr_en == ((res_reg || res_mem) && req_write))); // R11
    end
  end

endmodule

bind sracc_perm_check sracc_perm_check_chk #(.OFS_W(OFS_W)) u_chk (
  .req_lvl     (req_lvl),
  .req_write   (req_write),
  .req_alias   (req_alias),
  .feat_on     (feat_on),
  .top_present (top_present),
  .top_en      (top_en),
  .nv_bits     (nv_bits),
  .res_undef   (res_undef),
  .res_trap    (res_trap),
  .res_reg     (res_reg),
  .res_mem     (res_mem),
  .trap_lvl    (trap_lvl),
  .trap_cls    (trap_cls),
  .reg_sel_l2  (reg_sel_l2),
  .mem_ofs     (mem_ofs),
  .rd_en       (rd_en),
  .wr_en       (wr_en)
);

// File: tb/test_sracc_perm_check.sv
`timescale 1ns/1ps
module test_sracc_perm_check;

  // Stimulus layout: [18:17] level, [16] write, [15] alias, [14] feature,
  // [13] top present, [12] top enable, [11] l2 trap, [10:9] l2 enable,
  // [8] host, [7:5] nv bits, [4:3] l1 enable, [2] sdd prio, [1] sdd undef,
  // [0] level 2 live.
  logic [18:0] vin;
  logic        clk;
  int          checks;
  int          errors;
  int          cyc;
  bit          done;

  logic res_undef, res_trap, res_reg, res_mem, reg_sel_l2, rd_en, wr_en;
  logic [1:0]  trap_lvl;
  logic [5:0]  trap_cls;
  logic [11:0] mem_ofs;

  sracc_perm_check i_sracc_perm_check (
    .req_lvl (vin[18:17]), .req_write (vin[16]), .req_alias (vin[15]),
    .feat_on (vin[14]), .top_present (vin[13]), .top_en (vin[12]),
    .l2_trap (vin[11]), .l2_en (vin[10:9]), .host_mode (vin[8]),
    .l2_live (vin[0]), .nv_bits (vin[7:5]), .l1_en (vin[4:3]),
    .sdd_prio (vin[2]), .sdd_undef (vin[1]),
    .res_undef (res_undef), .res_trap (res_trap), .res_reg (res_reg),
    .res_mem (res_mem), .trap_lvl (trap_lvl), .trap_cls (trap_cls),
    .reg_sel_l2 (reg_sel_l2), .mem_ofs (mem_ofs), .rd_en (rd_en),
    .wr_en (wr_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Output packing: undef,trap,reg,mem, tl[2], tc[6], sel, ofs[12], rd, wr
  function automatic logic [26:0] e_undef();
    return {4'b1000, 2'd0, 6'd0, 1'b0, 12'd0, 2'b00};
  endfunction
  function automatic logic [26:0] e_trap(input logic [1:0] l, input logic [5:0] c);
    return {4'b0100, l, c, 1'b0, 12'd0, 2'b00};
  endfunction
  function automatic logic [26:0] e_reg(input logic sel, input logic w);
    return {4'b0010, 2'd0, 6'd0, sel, 12'd0, ~w, w};
  endfunction
  function automatic logic [26:0] e_mem(input logic w);
    return {4'b0001, 2'd0, 6'd0, 1'b0, 12'h1E0, ~w, w};
  endfunction

  function automatic logic [26:0] ref_model(input logic [18:0] s);
    logic [1:0] lv; logic w, al, ft, tp, te, tz, hm, lk, pr, su;
    logic [1:0] ze, le; logic [2:0] nv;
    logic ez_bad;
    lv = s[18:17]; w = s[16]; al = s[15]; ft = s[14]; tp = s[13];
    te = s[12]; tz = s[11]; ze = s[10:9]; hm = s[8]; nv = s[7:5];
    le = s[4:3]; pr = s[2]; su = s[1]; lk = s[0];
    ez_bad = tp && !te;
    if (!ft || lv == 2'd0) return e_undef();
    if (lv == 2'd3) return te ? e_reg(!al, w) : e_trap(2'd3, 6'h19);
    if (lv == 2'd1 && !al) return nv[0] ? e_trap(2'd2, 6'h18) : e_undef();
    if (ez_bad && pr) return e_undef();
    if (lv == 2'd1 && le[0] == 1'b0) return e_trap(2'd1, 6'h19);
    if (tz && !hm && (lv == 2'd2 || lk)) return e_trap(2'd2, 6'h19);
    if (hm && !ze[0]) return e_trap(2'd2, 6'h19);
    if (ez_bad) return su ? e_undef() : e_trap(2'd3, 6'h19);
    if (lv == 2'd1) return (nv == 3'b111) ? e_mem(w) : e_reg(1'b0, w);
    return e_reg(!al || hm, w);
  endfunction

  function automatic logic [26:0] got();
    return {res_undef, res_trap, res_reg, res_mem, trap_lvl, trap_cls,
            reg_sel_l2, mem_ofs, rd_en, wr_en};
  endfunction

  task automatic chk(input string tag, input logic [18:0] s, input logic [26:0] exp);
    vin = s;
    #0.5;
    checks++;
    if (got() !== exp) begin
      errors++;
      $display("FAIL %s stim=%h actual=%h expected=%h", tag, s, got(), exp);
    end
    #0.5;
  endtask

  function automatic logic [18:0] mk(input logic [1:0] lv, input logic w,
      input logic al, input logic tp, input logic te, input logic tz,
      input logic [1:0] ze, input logic hm, input logic [2:0] nv,
      input logic [1:0] le, input logic pr, input logic su, input logic lk);
    return {lv, w, al, 1'b1, tp, te, tz, ze, hm, nv, le, pr, su, lk};
  endfunction

  task automatic t_idle();
    chk("R1 idle", 19'd0, e_undef());
    chk("R1 nofeat", mk(2'd3,0,0,1,1,0,2'b11,0,3'd0,2'b11,0,0,1) & ~19'h4000, e_undef());
    chk("R1 lvl0", mk(2'd0,0,1,1,1,0,2'b11,0,3'd0,2'b11,0,0,1), e_undef());
  endtask

  task automatic t_l1_own();
    chk("R2 nv0", mk(2'd1,0,0,1,1,0,2'b11,0,3'b001,2'b11,0,0,1), e_trap(2'd2, 6'h18));
    chk("R2 nooff", mk(2'd1,0,0,1,1,0,2'b11,0,3'b110,2'b11,0,0,1), e_undef());
  endtask

  task automatic t_l2_chain();
    chk("R3 prio", mk(2'd2,0,0,1,0,1,2'b00,0,3'd0,2'b11,1,0,1), e_undef());
    chk("R4 tz", mk(2'd2,0,0,1,1,1,2'b11,0,3'd0,2'b11,0,0,1), e_trap(2'd2, 6'h19));
    chk("R4 hostzen", mk(2'd2,0,1,1,1,1,2'b10,1,3'd0,2'b11,0,0,1), e_trap(2'd2, 6'h19));
    chk("R5 ez trap", mk(2'd2,0,0,1,0,0,2'b11,0,3'd0,2'b11,0,0,1), e_trap(2'd3, 6'h19));
    chk("R5 ez undef", mk(2'd2,0,0,1,0,0,2'b11,0,3'd0,2'b11,0,1,1), e_undef());
    chk("R5 no top", mk(2'd2,1,0,0,0,0,2'b11,0,3'd0,2'b11,1,1,1), e_reg(1'b1, 1'b1));
  endtask

  task automatic t_l3();
    chk("R6 ez0", mk(2'd3,0,0,1,0,1,2'b00,1,3'd7,2'b00,1,1,0), e_trap(2'd3, 6'h19));
    chk("R6 own", mk(2'd3,0,0,1,1,1,2'b00,1,3'd7,2'b00,0,0,0), e_reg(1'b1, 1'b0));
    chk("R6 alias", mk(2'd3,1,1,1,1,1,2'b00,1,3'd7,2'b00,0,0,0), e_reg(1'b0, 1'b1));
  endtask

  task automatic t_l1_alias();
    chk("R7 l1trap", mk(2'd1,0,1,1,1,1,2'b00,1,3'd0,2'b10,0,0,1), e_trap(2'd1, 6'h19));
    chk("R7 prio first", mk(2'd1,0,1,1,0,0,2'b11,0,3'd0,2'b00,1,0,1), e_undef());
    chk("R8 tz gated", mk(2'd1,0,1,1,1,1,2'b11,0,3'd0,2'b01,0,0,0), e_reg(1'b0, 1'b0));
    chk("R8 tz live", mk(2'd1,0,1,1,1,1,2'b11,0,3'd0,2'b01,0,0,1), e_trap(2'd2, 6'h19));
    chk("R8 host zen", mk(2'd1,0,1,1,1,0,2'b00,1,3'd0,2'b01,0,0,0), e_trap(2'd2, 6'h19));
    chk("R9 mem", mk(2'd1,1,1,1,1,0,2'b11,0,3'b111,2'b01,0,0,1), e_mem(1'b1));
    chk("R9 not full", mk(2'd1,0,1,1,1,0,2'b11,0,3'b011,2'b01,0,0,1), e_reg(1'b0, 1'b0));
  endtask

  task automatic t_l2_route();
    chk("R10 own", mk(2'd2,0,0,1,1,0,2'b11,0,3'd0,2'b00,0,0,1), e_reg(1'b1, 1'b0));
    chk("R10 alias host", mk(2'd2,0,1,1,1,0,2'b01,1,3'd0,2'b00,0,0,1), e_reg(1'b1, 1'b0));
    chk("R10 alias guest", mk(2'd2,0,1,1,1,0,2'b00,0,3'd0,2'b00,0,0,1), e_reg(1'b0, 1'b0));
  endtask

  task automatic t_direction();
    chk("R11 read", mk(2'd2,0,0,1,1,0,2'b11,0,3'd0,2'b00,0,0,1), e_reg(1'b1, 1'b0));
    chk("R11 write", mk(2'd2,1,0,1,1,0,2'b11,0,3'd0,2'b00,0,0,1), e_reg(1'b1, 1'b1));
    chk("R11 trap write", mk(2'd2,1,0,1,1,1,2'b11,0,3'd0,2'b00,0,0,1), e_trap(2'd2, 6'h19));
  endtask

  task automatic t_sweep();
    for (int v = 0; v < (1 << 19); v++) begin
      chk("R12 sweep", v[18:0], ref_model(v[18:0]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; cyc = 0; done = 1'b0;
    vin = '0;
    #5;
    t_idle();
    t_l1_own();
    t_l2_chain();
    t_l3();
    t_l1_alias();
    t_l2_route();
    t_direction();
    t_sweep();
    finish_run();
  end

endmodule